// File: doc/BRIEF.md
# Lane-Addressable Matrix Register File

This block is a small SIMD register file of eight wide registers that can be viewed in two directions. Each register is a row of eight 12-bit lanes, so the whole file is an 8×8 matrix whose element [i][j] is lane j of register i. Rows are read and written like any ordinary register file. A column write also exists: it takes eight packed bytes, zero-extends each to a 12-bit lane, and drops byte k into the chosen lane of register k, for every k at once.

The column path turns band-interleaved pixel data into band-separated registers without any shuffle operations. If eight column writes are fed with eight-byte windows of an RGB byte stream, and each window starts six bytes after the previous one, then every register ends up holding a single colour component of either the even pixels or the odd pixels. Two combinational read ports serve the datapath. A write that lands in the same cycle as a read is forwarded, so the read already returns the new value.

Top module: `lane_matrix_rf`

## Requirements
- R1: After reset every register reads as all zeros on both read ports.
- R2: With `wr_en`=1 and `wr_col_mode`=0 (row mode), the whole 96-bit `wr_row` is stored in register `wr_reg` and can be read from the next cycle.
- R3: With `wr_en`=1 and `wr_col_mode`=1 (column mode), byte k of `wr_col_bytes` (bits 8k+7..8k) is stored into lane `wr_lane` (bits 12j+11..12j, where j=`wr_lane`) of register k, for all eight registers k.
- R4: A column write zero-extends each byte, so bits 12j+11..12j+8 of the written lane become 0 even when the byte's top bit is set.
- R5: A column write leaves every lane other than `wr_lane` unchanged in all registers, including the boundary lanes 0 and 7.
- R6: A row write leaves every register other than `wr_reg` unchanged.
- R7: With `wr_en`=0 no register changes, whatever the mode, index and data inputs carry.
- R8: The two read ports are independent and combinational: `rd_a_data` and `rd_b_data` show the registers chosen by `rd_a_idx` and `rd_b_idx` in the same cycle.
- R9: A read of a register that is being written in the same cycle returns the value it will hold after the edge. This holds for a row write to that register and for a column write to any register.
- R10: Eight column writes to lanes 0..7, where the window for lane j begins at byte 6j of an interleaved R,G,B byte stream, leave the red, green and blue of even pixels in registers 0, 1 and 2 and those of odd pixels in registers 3, 4 and 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write enable for the single write port |
| wr_col_mode | input | 1 | 0 = row write, 1 = column write |
| wr_reg | input | 3 | Target register for a row write |
| wr_lane | input | 3 | Target lane for a column write |
| wr_row | input | 96 | Row write data, lane j in bits 12j+11..12j |
| wr_col_bytes | input | 64 | Column write data, byte k goes to register k |
| rd_a_idx | input | 3 | Register index for read port A |
| rd_a_data | output | 96 | Read port A data |
| rd_b_idx | input | 3 | Register index for read port B |
| rd_b_data | output | 96 | Read port B data |

## Verification
Writes and reads fall in the same cycle, and this is where forwarding must produce the post-edge value in both write modes. The bench points one or both read ports at the written register, or at arbitrary registers during a column write, in the very cycle of the write. A behavioural matrix model predicts each read by applying the pending write to its own copy before comparing. Directed cycles cover forwarding on lanes 0 and 7 and reads of untouched registers during a row write. A long random run then mixes writes, idle cycles and reads on every clock.

// File: rtl/lane_matrix_pkg.sv
package lane_matrix_pkg;
  typedef enum logic {
    WR_ROW = 1'b0,
    WR_COL = 1'b1
  } wr_mode_e;
endpackage

// File: rtl/lane_widen.sv
module lane_widen #(
  parameter int NREG   = 8,
  parameter int BYTE_W = 8,
  parameter int LANE_W = 12
) (
  input  logic [NREG*BYTE_W-1:0] bytes_in,
  output logic [NREG*LANE_W-1:0] lanes_out
);
  localparam int PAD_W = LANE_W - BYTE_W;

  for (genvar k = 0; k < NREG; k++) begin : g_widen
    if (PAD_W > 0) begin : g_pad
      assign lanes_out[k*LANE_W +: LANE_W] = {{PAD_W{1'b0}}, bytes_in[k*BYTE_W +: BYTE_W]};
    end else begin : g_cut
      assign lanes_out[k*LANE_W +: LANE_W] = bytes_in[k*BYTE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/lane_row_store.sv
module lane_row_store
  import lane_matrix_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int LANES  = 8,
  parameter int LANE_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  wr_mode_e                  wr_mode,
  input  logic [$clog2(NREG)-1:0]   wr_reg,
  input  logic [$clog2(LANES)-1:0]  wr_lane,
  input  logic [LANES*LANE_W-1:0]   row_data,
  input  logic [NREG*LANE_W-1:0]    col_lanes,
  output logic [NREG*LANES*LANE_W-1:0] next_rows
);
  localparam int ROW_W = LANES * LANE_W;

  logic [NREG-1:0][ROW_W-1:0] rows_q;
  logic [NREG-1:0][ROW_W-1:0] rows_d;

  // next-state: the pending write applied to the current contents
  always_comb begin
    rows_d = rows_q;
    if (wr_en) begin
      if (wr_mode == WR_COL) begin
        for (int k = 0; k < NREG; k++) begin
          rows_d[k][int'(wr_lane)*LANE_W +: LANE_W] = col_lanes[k*LANE_W +: LANE_W];
        end
      end else begin
        rows_d[wr_reg] = row_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rows_q <= '0;
    end else if (wr_en) begin
      rows_q <= rows_d;
    end
  end

  assign next_rows = rows_d;

  function automatic logic [ROW_W-1:0] keep_mask(input logic [$clog2(LANES)-1:0] ln);
    logic [ROW_W-1:0] m;
    m = '1;
    m[int'(ln)*LANE_W +: LANE_W] = '0;
    return m;
  endfunction

  for (genvar k = 0; k < NREG; k++) begin : g_chk
    // R2
    row_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_mode == WR_ROW && int'(wr_reg) == k) |=> rows_q[k] == $past(row_data));
    // R6
    row_write_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_mode == WR_ROW && int'(wr_reg) != k) |=> $stable(rows_q[k]));
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en) |=> $stable(rows_q[k]));
    // R3
    col_lane_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_mode == WR_COL) |=>
        rows_q[k][int'($past(wr_lane))*LANE_W +: LANE_W] == $past(col_lanes[k*LANE_W +: LANE_W]));
    // R5
    col_other_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_mode == WR_COL) |=>
        ((rows_q[k] ^ $past(rows_q[k])) & keep_mask($past(wr_lane))) == '0);
  end
endmodule

// File: rtl/lane_read_port.sv
module lane_read_port #(
  parameter int NREG  = 8,
  parameter int ROW_W = 96
) (
  input  logic [NREG*ROW_W-1:0]   rows,
  input  logic [$clog2(NREG)-1:0] idx,
  output logic [ROW_W-1:0]        data
);
  assign data = rows[int'(idx)*ROW_W +: ROW_W];
endmodule

// File: rtl/lane_matrix_rf.sv
module lane_matrix_rf
  import lane_matrix_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int LANES  = 8,
  parameter int LANE_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         wr_col_mode,
  input  logic [$clog2(NREG)-1:0]      wr_reg,
  input  logic [$clog2(LANES)-1:0]     wr_lane,
  input  logic [LANES*LANE_W-1:0]      wr_row,
  input  logic [NREG*BYTE_W-1:0]       wr_col_bytes,
  input  logic [$clog2(NREG)-1:0]      rd_a_idx,
  output logic [LANES*LANE_W-1:0]      rd_a_data,
  input  logic [$clog2(NREG)-1:0]      rd_b_idx,
  output logic [LANES*LANE_W-1:0]      rd_b_data
);
  localparam int ROW_W = LANES * LANE_W;

  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign core_rst_n = rst_sync_q[1];

  wr_mode_e                 mode;
  logic [NREG*LANE_W-1:0]   col_lanes;
  logic [NREG*ROW_W-1:0]    next_rows;

  assign mode = wr_col_mode ? WR_COL : WR_ROW;

  lane_widen #(.NREG(NREG), .BYTE_W(BYTE_W), .LANE_W(LANE_W)) u_widen (
    .bytes_in  (wr_col_bytes),
    .lanes_out (col_lanes)
  );

  lane_row_store #(.NREG(NREG), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .wr_en     (wr_en),
    .wr_mode   (mode),
    .wr_reg    (wr_reg),
    .wr_lane   (wr_lane),
    .row_data  (wr_row),
    .col_lanes (col_lanes),
    .next_rows (next_rows)
  );

  lane_read_port #(.NREG(NREG), .ROW_W(ROW_W)) u_rd_a (
    .rows (next_rows),
    .idx  (rd_a_idx),
    .data (rd_a_data)
  );

  lane_read_port #(.NREG(NREG), .ROW_W(ROW_W)) u_rd_b (
    .rows (next_rows),
    .idx  (rd_b_idx),
    .data (rd_b_data)
  );

  // R4
  col_zero_extend_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_en && wr_col_mode) |=>
      (rd_a_data[int'($past(wr_lane))*LANE_W + BYTE_W +: (LANE_W-BYTE_W)] == '0)
      || (rd_a_idx != $past(rd_a_idx)) || wr_en);
endmodule

// File: tb/lane_matrix_rf_test.sv
`timescale 1ns/1ps
module lane_matrix_rf_test;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        wr_col_mode;
  logic [2:0]  wr_reg;
  logic [2:0]  wr_lane;
  logic [95:0] wr_row;
  logic [63:0] wr_col_bytes;
  logic [2:0]  rd_a_idx;
  logic [95:0] rd_a_data;
  logic [2:0]  rd_b_idx;
  logic [95:0] rd_b_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [11:0] refm [8][8];
  logic [7:0]  stream [64];

  lane_matrix_rf uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_col_mode(wr_col_mode),
    .wr_reg(wr_reg), .wr_lane(wr_lane), .wr_row(wr_row), .wr_col_bytes(wr_col_bytes),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // expected value of register r as seen by a read in the current cycle
  function automatic logic [95:0] expect_row(input int r);
    logic [95:0] v;
    for (int j = 0; j < 8; j++) v[j*12 +: 12] = refm[r][j];
    if (wr_en) begin
      if (wr_col_mode) v[int'(wr_lane)*12 +: 12] = {4'h0, wr_col_bytes[r*8 +: 8]};
      else if (int'(wr_reg) == r) v = wr_row;
    end
    return v;
  endfunction

  task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic commit();
    if (wr_en) begin
      if (wr_col_mode) begin
        for (int k = 0; k < 8; k++) refm[k][wr_lane] = {4'h0, wr_col_bytes[k*8 +: 8]};
      end else begin
        for (int j = 0; j < 8; j++) refm[wr_reg][j] = wr_row[j*12 +: 12];
      end
    end
  endtask

  task automatic step(input string tag, input logic en, input logic col,
                      input logic [2:0] rg, input logic [2:0] ln,
                      input logic [95:0] row, input logic [63:0] cb,
                      input logic [2:0] ra, input logic [2:0] rb);
    @(negedge clk);
    wr_en = en; wr_col_mode = col; wr_reg = rg; wr_lane = ln;
    wr_row = row; wr_col_bytes = cb; rd_a_idx = ra; rd_b_idx = rb;
    #5;
    check(tag, rd_a_data, expect_row(int'(ra)));
    check(tag, rd_b_data, expect_row(int'(rb)));
    @(posedge clk);
    #1;
    commit();
  endtask

  initial begin
    #(20 * 60000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] cb;
    logic [95:0] v;
    rst_n = 0; wr_en = 0; wr_col_mode = 0; wr_reg = 0; wr_lane = 0;
    wr_row = '0; wr_col_bytes = '0; rd_a_idx = 0; rd_b_idx = 0;
    for (int i = 0; i < 8; i++) for (int j = 0; j < 8; j++) refm[i][j] = 12'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);

    // R1: reset contents on both ports
    for (int r = 0; r < 8; r += 2) step("R1", 0, 0, 0, 0, '0, '0, 3'(r), 3'(r + 1));

    // R2 + R9: row write with same-cycle read, R6 on the neighbour
    step("R9", 1, 0, 3'd3, 0, 96'h123456789abcdef012345678, '0, 3'd3, 3'd2);
    step("R2", 0, 0, 0, 0, '0, '0, 3'd3, 3'd4);
    step("R6", 1, 0, 3'd0, 0, {8{12'hfff}}, '0, 3'd3, 3'd0);

    // R7: full data on the inputs but enable low, both modes
    step("R7", 0, 1, 3'd3, 3'd2, {8{12'h5a5}}, 64'hffffffffffffffff, 3'd3, 3'd0);
    step("R7", 0, 0, 3'd3, 3'd2, {8{12'h5a5}}, 64'hffffffffffffffff, 3'd3, 3'd0);

    // R3 + R4 + R9: column write into lane 7 with high-bit bytes, forwarded reads
    step("R9", 1, 1, 0, 3'd7, '0, 64'hf0e1d2c3b4a59687, 3'd0, 3'd7);
    step("R4", 0, 0, 0, 0, '0, '0, 3'd0, 3'd3);
    // R5: lane 0 boundary, other lanes keep data
    step("R5", 1, 1, 0, 3'd0, '0, 64'h8877665544332211, 3'd3, 3'd5);
    step("R3", 0, 0, 0, 0, '0, '0, 3'd0, 3'd3);

    // R8: independent ports, random mixed traffic compared every cycle
    for (int n = 0; n < 400; n++) begin
      step("R8", 1'($urandom), 1'($urandom), 3'($urandom), 3'($urandom),
           {$urandom, $urandom, $urandom}, {$urandom, $urandom},
           3'($urandom), 3'($urandom));
    end

    // R10: stride-six column loads from an interleaved RGB stream
    for (int i = 0; i < 64; i++) stream[i] = 8'($urandom);
    for (int j = 0; j < 8; j++) begin
      for (int k = 0; k < 8; k++) cb[k*8 +: 8] = stream[6*j + k];
      step("R10", 1, 1, 0, 3'(j), '0, cb, 3'(j), 3'd0);
    end
    for (int r = 0; r < 6; r++) begin
      step("R10", 0, 0, 0, 0, '0, '0, 3'(r), 3'(r));
      for (int j = 0; j < 8; j++) v[j*12 +: 12] = {4'h0, stream[6*j + r]};
      check("R10", rd_a_data, v);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule